// File: doc/BRIEF.md
# Shared Victim Cache with Sharing-Aware Retention

This block is the last cache level behind four cores. It never fetches from memory. Its only source of lines is the victim port: when a core's private second-level cache evicts a line, that line is written here. Any of the four cores can then look the line up, whichever core inserted it. A hit returns the line to the requesting core on a shared response port. A miss reports a miss and nothing more. Fetching from memory after a miss is left to the surrounding logic.

What happens to the entry after a hit depends on the request type:

- A code fetch always leaves the line in place.
- A data load leaves the line in place only if the line has already been shared between cores.
- Otherwise the data load takes the line out, and the freed way becomes the next one to be replaced.

Each way records which core inserted its line and whether a different core has hit on it since. When a valid dirty line is displaced by replacement, it is reported on an eviction output so that a writeback path can take it.

Top module: `shared_victim_cache`

## Requirements
- R1: After reset every way is invalid. Every lookup misses, and no response or eviction is reported until a request is accepted.
- R2: An address is split into a set index (the low log2(SETS) bits) and a tag (the remaining high bits). A line inserted by any core hits for a lookup from any core with the same address and returns the inserted data.
- R3: Inserting an address whose tag is already present in its set overwrites that way in place, with the new data and the new dirty flag. No second copy is allocated and no eviction is reported.
- R4: A new address inserted into a set replaces the least recently used way. Both inserts and retained hits make the way they touch the most recently used. After reset, the ways of each set are ordered so that way 0 is replaced first, then way 1, and so on.
- R5: A code-fetch lookup that hits returns the line and leaves it valid.
- R6: A data-load lookup that hits a line whose sharing flag is clear returns the line and then invalidates it, so the next lookup of that address misses.
- R7: A hit by a core other than the inserting core sets the line's sharing flag. A later data-load hit on a line whose flag was already set keeps the line. The decision uses the flag as it stood before the current hit.
- R8: When an insert displaces a valid dirty line with a different tag, the eviction output pulses for one cycle, one cycle after the insert is accepted. It carries the displaced line's full address and data. Displacing a clean or invalid way produces no pulse.
- R9: Each accepted lookup produces exactly one response in the following cycle. The response carries the requesting core number, the hit flag, and on a hit the data and the line's dirty flag.
- R10: One operation is accepted per cycle, in fixed priority: the insert first, then core 0, core 1, core 2, core 3. Requests that lose see their ready low and are served in later cycles while they stay valid. The insert port is always ready.
- R11: A way that a data load invalidates moves to the least recently used position, so the next insert of a new tag into that set reuses it without evicting a valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Victim insert request |
| insReady | output | 1 | Insert accepted (always high) |
| insAddr | input | ADDR_W | Line address of the victim |
| insData | input | DATA_W | Victim line data |
| insDirty | input | 1 | Victim is modified relative to memory |
| insCore | input | 2 | Core that evicted the victim |
| reqValid | input | 4 | Per-core lookup request |
| reqReady | output | 4 | Per-core lookup grant |
| reqAddr | input | 4*ADDR_W | Per-core lookup addresses, core i at bits [i*ADDR_W +: ADDR_W] |
| reqIsCode | input | 4 | Per-core flag: 1 = code fetch, 0 = data load |
| rspValid | output | 1 | Response present |
| rspCore | output | 2 | Core the response belongs to |
| rspHit | output | 1 | Lookup hit |
| rspData | output | DATA_W | Line data on a hit |
| rspDirty | output | 1 | Returned line is dirty |
| evictValid | output | 1 | A dirty line was displaced |
| evictAddr | output | ADDR_W | Address of the displaced line |
| evictData | output | DATA_W | Data of the displaced line |

## Verification
Directed sequences separate the retention rules:

- Code versus data lookups by the inserting core tell a kept line from a dropped one.
- A data lookup by a foreign core with no prior sharing tells the pre-hit flag from the post-hit flag.
- A foreign code hit followed by data loads confirms that the sharing history is retained.

Filling a full set of 32 ways, with a hit in between, shows whether replacement follows recency or insertion order. A re-insert of an existing tag shows in-place overwrite, because the set then holds 32 distinct lines without any eviction. A cycle with all five requesters valid shows the grant order. Random mixes of inserts and lookups over a tag pool larger than the associativity drive sets past full, exercising invalidation, replacement and dirty eviction together.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int NCORES = 4;
  localparam int CORE_W = 2;

  // Strobes from the arbiter to the storage datapath.
  typedef struct packed {
    logic              doIns;
    logic              doLook;
    logic              isCode;
    logic [CORE_W-1:0] core;
  } strobe_t;
endpackage

// File: rtl/svc_ctrl.sv
module svc_ctrl
  import svc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     insValid,
  input  logic [ADDR_W-1:0]        insAddr,
  input  logic [NCORES-1:0]        reqValid,
  input  logic [NCORES*ADDR_W-1:0] reqAddr,
  input  logic [NCORES-1:0]        reqIsCode,
  output logic [NCORES-1:0]        reqReady,
  output strobe_t                  strobe,
  output logic [ADDR_W-1:0]        opAddr
);
  logic granted;

  // Fixed priority: insert, then core 0 upward.
  always_comb begin
    strobe   = '0;
    reqReady = '0;
    opAddr   = insAddr;
    granted  = 1'b0;
    if (insValid) begin
      strobe.doIns = 1'b1;
    end else begin
      for (int i = 0; i < NCORES; i++) begin
        if (reqValid[i] && !granted) begin
          granted       = 1'b1;
          reqReady[i]   = 1'b1;
          strobe.doLook = 1'b1;
          strobe.isCode = reqIsCode[i];
          strobe.core   = CORE_W'(i);
          opAddr        = reqAddr[i*ADDR_W +: ADDR_W];
        end
      end
    end
  end

  // R10: at most one lookup grant, and none while an insert is pending
  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady) && !(insValid && (|reqReady)));

  for (genvar g = 1; g < NCORES; g++) begin : gPrio
    // R10: a core is granted only when no lower-numbered core is requesting
    a_r10_lower_first: assert property (@(posedge clk) disable iff (!rstN)
      reqReady[g] |-> (reqValid[g-1:0] == '0));
  end
endmodule

// File: rtl/svc_datapath.sv
module svc_datapath
  import svc_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobe,
  input  logic [TAG_W+$clog2(SETS)-1:0]  opAddr,
  input  logic [DATA_W-1:0]              insData,
  input  logic                           insDirty,
  input  logic [CORE_W-1:0]              insCore,
  output logic                           rspValid,
  output logic [CORE_W-1:0]              rspCore,
  output logic                           rspHit,
  output logic [DATA_W-1:0]              rspData,
  output logic                           rspDirty,
  output logic                           evictValid,
  output logic [TAG_W+$clog2(SETS)-1:0]  evictAddr,
  output logic [DATA_W-1:0]              evictData
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic              validQ  [SETS][WAYS];
  logic              dirtyQ  [SETS][WAYS];
  logic              sharedQ [SETS][WAYS];
  logic [CORE_W-1:0] srcQ    [SETS][WAYS];
  logic [WAY_W-1:0]  ageQ    [SETS][WAYS];
  logic [TAG_W-1:0]  tagQ    [SETS][WAYS];
  logic [DATA_W-1:0] dataQ   [SETS][WAYS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  hitVec, lruVec;
  logic             hitAny, keepLine, lookHit, touch, demote;
  logic [WAY_W-1:0] hitWay, lruWay, tgtWay, tgtAge;

  assign idx = opAddr[IDX_W-1:0];
  assign tag = opAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : gCmp
    assign hitVec[w] = validQ[idx][w] && (tagQ[idx][w] == tag);
    assign lruVec[w] = (ageQ[idx][w] == OLDEST);
  end

  always_comb begin
    hitAny = 1'b0;
    hitWay = '0;
    lruWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (lruVec[w]) lruWay = WAY_W'(w);
    end
  end

  assign tgtWay   = (strobe.doIns && !hitAny) ? lruWay : hitWay;
  assign tgtAge   = ageQ[idx][tgtWay];
  assign keepLine = strobe.isCode || sharedQ[idx][hitWay];
  assign lookHit  = strobe.doLook && hitAny;
  assign touch    = strobe.doIns || (lookHit && keepLine);
  assign demote   = lookHit && !keepLine;

  // Control state and recency ordering.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validQ[s][w]  <= 1'b0;
          dirtyQ[s][w]  <= 1'b0;
          sharedQ[s][w] <= 1'b0;
          srcQ[s][w]    <= '0;
          ageQ[s][w]    <= WAY_W'(WAYS - 1 - w);
        end
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch) begin
          if (WAY_W'(w) == tgtWay) ageQ[idx][w] <= '0;
          else if (ageQ[idx][w] < tgtAge) ageQ[idx][w] <= ageQ[idx][w] + 1'b1;
        end else if (demote) begin
          if (WAY_W'(w) == tgtWay) ageQ[idx][w] <= OLDEST;
          else if (ageQ[idx][w] > tgtAge) ageQ[idx][w] <= ageQ[idx][w] - 1'b1;
        end
      end
      if (strobe.doIns) begin
        validQ[idx][tgtWay]  <= 1'b1;
        dirtyQ[idx][tgtWay]  <= insDirty;
        sharedQ[idx][tgtWay] <= 1'b0;
        srcQ[idx][tgtWay]    <= insCore;
      end else if (lookHit) begin
        if (srcQ[idx][hitWay] != strobe.core) sharedQ[idx][hitWay] <= 1'b1;
        if (!keepLine) validQ[idx][hitWay] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doIns) begin
      tagQ[idx][tgtWay]  <= tag;
      dataQ[idx][tgtWay] <= insData;
    end
  end

  // Registered response and eviction report.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspCore    <= '0;
      rspHit     <= 1'b0;
      rspData    <= '0;
      rspDirty   <= 1'b0;
      evictValid <= 1'b0;
      evictAddr  <= '0;
      evictData  <= '0;
    end else begin
      rspValid   <= strobe.doLook;
      rspCore    <= strobe.core;
      rspHit     <= lookHit;
      rspData    <= lookHit ? dataQ[idx][hitWay] : '0;
      rspDirty   <= lookHit && dirtyQ[idx][hitWay];
      evictValid <= strobe.doIns && !hitAny && validQ[idx][lruWay] && dirtyQ[idx][lruWay];
      evictAddr  <= {tagQ[idx][lruWay], idx};
      evictData  <= dataQ[idx][lruWay];
    end
  end

  // Bookkeeping for the retention checks below.
  logic [IDX_W-1:0] lastIdx;
  logic [WAY_W-1:0] lastWay;
  logic             lastCode, lastShared;
  always_ff @(posedge clk) begin
    lastIdx    <= idx;
    lastWay    <= hitWay;
    lastCode   <= strobe.isCode;
    lastShared <= sharedQ[idx][hitWay];
  end

  // R4: the recency ordering always names exactly one oldest way
  a_r4_single_oldest: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doIns || strobe.doLook) |-> $onehot(lruVec));
  // R3: a tag is never held twice in one set
  a_r3_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hitVec) <= 1);
  // R5: a code hit leaves the line valid
  a_r5_code_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && lastCode) |-> validQ[lastIdx][lastWay]);
  // R6: a data hit on an unshared line drops it
  a_r6_data_drops: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && !lastCode && !lastShared) |-> !validQ[lastIdx][lastWay]);
endmodule

// File: rtl/shared_victim_cache.sv
module shared_victim_cache
  import svc_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  localparam int ADDR_W = TAG_W + $clog2(SETS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     insValid,
  output logic                     insReady,
  input  logic [ADDR_W-1:0]        insAddr,
  input  logic [DATA_W-1:0]        insData,
  input  logic                     insDirty,
  input  logic [CORE_W-1:0]        insCore,
  input  logic [NCORES-1:0]        reqValid,
  output logic [NCORES-1:0]        reqReady,
  input  logic [NCORES*ADDR_W-1:0] reqAddr,
  input  logic [NCORES-1:0]        reqIsCode,
  output logic                     rspValid,
  output logic [CORE_W-1:0]        rspCore,
  output logic                     rspHit,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspDirty,
  output logic                     evictValid,
  output logic [ADDR_W-1:0]        evictAddr,
  output logic [DATA_W-1:0]        evictData
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] opAddr;

  assign insReady = 1'b1;

  svc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insAddr(insAddr),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqIsCode(reqIsCode),
    .reqReady(reqReady), .strobe(strobe), .opAddr(opAddr)
  );

  svc_datapath #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W), .TAG_W(TAG_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opAddr(opAddr),
    .insData(insData), .insDirty(insDirty), .insCore(insCore),
    .rspValid(rspValid), .rspCore(rspCore), .rspHit(rspHit), .rspData(rspData),
    .rspDirty(rspDirty), .evictValid(evictValid), .evictAddr(evictAddr),
    .evictData(evictData)
  );

  // R9: an accepted lookup is answered in the next cycle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & reqReady)) |=> rspValid);
  // R9: no response without an accepted lookup
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(|(reqValid & reqReady)));
  // R8: an eviction report follows an insert
  a_r8_evict_after_insert: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> $past(insValid));
endmodule

// File: tb/test_shared_victim_cache.sv
module test_shared_victim_cache;
  localparam int SETS = 4, WAYS = 32, DATA_W = 32, TAG_W = 8;
  localparam int ADDR_W = TAG_W + $clog2(SETS);

  logic clk = 1'b0, rstN = 1'b0;
  logic insValid = 1'b0, insReady, insDirty = 1'b0;
  logic [ADDR_W-1:0] insAddr = '0;
  logic [DATA_W-1:0] insData = '0;
  logic [1:0] insCore = '0;
  logic [3:0] reqValid = '0, reqReady, reqIsCode = '0;
  logic [4*ADDR_W-1:0] reqAddr = '0;
  logic rspValid, rspHit, rspDirty, evictValid;
  logic [1:0] rspCore;
  logic [DATA_W-1:0] rspData, evictData;
  logic [ADDR_W-1:0] evictAddr;

  int checks = 0, failures = 0;

  shared_victim_cache #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_shared_victim_cache (
    .clk, .rstN, .insValid, .insReady, .insAddr, .insData, .insDirty, .insCore,
    .reqValid, .reqReady, .reqAddr, .reqIsCode, .rspValid, .rspCore, .rspHit,
    .rspData, .rspDirty, .evictValid, .evictAddr, .evictData
  );

  always #5 clk = ~clk;

  // Reference model kept from the requirements.
  bit mV [SETS][WAYS], mDirty [SETS][WAYS], mSh [SETS][WAYS];
  int mTag [SETS][WAYS], mSrc [SETS][WAYS], mAge [SETS][WAYS];
  logic [DATA_W-1:0] mD [SETS][WAYS];

  function automatic void mReset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mV[s][w] = 0; mDirty[s][w] = 0; mSh[s][w] = 0;
        mAge[s][w] = WAYS - 1 - w; mTag[s][w] = 0; mSrc[s][w] = 0;
      end
  endfunction

  function automatic int mFind(int s, int t);
    for (int w = 0; w < WAYS; w++) if (mV[s][w] && mTag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic void mTouch(int s, int k);
    int a = mAge[s][k];
    for (int w = 0; w < WAYS; w++) if (mAge[s][w] < a) mAge[s][w]++;
    mAge[s][k] = 0;
  endfunction

  function automatic void mDemote(int s, int k);
    int a = mAge[s][k];
    for (int w = 0; w < WAYS; w++) if (mAge[s][w] > a) mAge[s][w]--;
    mAge[s][k] = WAYS - 1;
  endfunction

  function automatic void mInsert(int addr, logic [DATA_W-1:0] d, bit dirty, int core,
                                  output bit ev, output int evA, output logic [DATA_W-1:0] evD);
    int s = addr % SETS, t = addr / SETS, k = mFind(s, t);
    ev = 0; evA = 0; evD = '0;
    if (k < 0) begin
      for (int w = 0; w < WAYS; w++) if (mAge[s][w] == WAYS - 1) k = w;
      ev = mV[s][k] && mDirty[s][k];
      evA = mTag[s][k] * SETS + s; evD = mD[s][k];
    end
    mV[s][k] = 1; mTag[s][k] = t; mD[s][k] = d; mDirty[s][k] = dirty;
    mSh[s][k] = 0; mSrc[s][k] = core;
    mTouch(s, k);
  endfunction

  function automatic void mLookup(int core, int addr, bit isCode,
                                  output bit hit, output logic [DATA_W-1:0] d, output bit dirty);
    int s = addr % SETS, t = addr / SETS, k = mFind(s, t);
    bit keep;
    hit = (k >= 0); d = '0; dirty = 0;
    if (hit) begin
      d = mD[s][k]; dirty = mDirty[s][k];
      keep = isCode || mSh[s][k];
      if (mSrc[s][k] != core) mSh[s][k] = 1;
      if (keep) mTouch(s, k);
      else begin mV[s][k] = 0; mDemote(s, k); end
    end
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic insertOp(int addr, logic [DATA_W-1:0] d, bit dirty, int core, string req);
    bit ev; int evA; logic [DATA_W-1:0] evD;
    mInsert(addr, d, dirty, core, ev, evA, evD);
    @(negedge clk);
    insValid = 1; insAddr = ADDR_W'(addr); insData = d; insDirty = dirty; insCore = 2'(core);
    @(negedge clk);
    insValid = 0;
    check(evictValid == ev, req, "evictValid", evictValid, ev);
    if (ev) begin
      check(evictAddr == ADDR_W'(evA), req, "evictAddr", evictAddr, evA);
      check(evictData == evD, req, "evictData", evictData, evD);
    end
  endtask

  task automatic lookupOp(int core, int addr, bit isCode, string req);
    bit hit, dirty; logic [DATA_W-1:0] d;
    mLookup(core, addr, isCode, hit, d, dirty);
    @(negedge clk);
    reqValid = 4'(1 << core); reqIsCode[core] = isCode;
    reqAddr[core*ADDR_W +: ADDR_W] = ADDR_W'(addr);
    @(negedge clk);
    reqValid = '0;
    check(rspValid && rspCore == 2'(core), "R9", "rspValid/rspCore", {rspValid, rspCore}, {1'b1, 2'(core)});
    check(rspHit == hit, req, "rspHit", rspHit, hit);
    if (hit) begin
      check(rspData == d, req, "rspData", rspData, d);
      check(rspDirty == dirty, "R9", "rspDirty", rspDirty, dirty);
    end
  endtask

  function automatic int adr(int s, int t);
    return t * SETS + s;
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(!rspValid && !evictValid, "R1", "idle outputs", {rspValid, evictValid}, 0);
    check(insReady && reqReady == 0, "R1", "ready state", {insReady, reqReady}, 5'h10);
    lookupOp(0, adr(1, 5), 1, "R1");
    lookupOp(3, adr(2, 9), 0, "R1");

    // R2, R5: cross-core hit, code keeps the line
    insertOp(adr(0, 1), 32'hA1A1_0001, 0, 2, "R2");
    lookupOp(0, adr(0, 1), 1, "R2");
    lookupOp(1, adr(0, 1), 1, "R5");
    lookupOp(2, adr(0, 1), 1, "R5");

    // R6: data load by the inserting core drops the line
    insertOp(adr(1, 2), 32'hB2B2_0002, 1, 1, "R2");
    lookupOp(1, adr(1, 2), 0, "R6");
    lookupOp(1, adr(1, 2), 0, "R6");

    // R7: foreign data hit without history drops; foreign code hit sets history
    insertOp(adr(2, 3), 32'hC3C3_0003, 0, 0, "R2");
    lookupOp(3, adr(2, 3), 0, "R7");
    lookupOp(3, adr(2, 3), 0, "R7");
    insertOp(adr(2, 4), 32'hD4D4_0004, 0, 0, "R2");
    lookupOp(1, adr(2, 4), 1, "R7");
    lookupOp(2, adr(2, 4), 0, "R7");
    lookupOp(0, adr(2, 4), 0, "R7");

    // R3, R8: in-place overwrite, then fill the set and evict the dirty line
    insertOp(adr(3, 10), 32'hE0E0_0001, 1, 0, "R3");
    insertOp(adr(3, 10), 32'hE0E0_0002, 1, 1, "R3");
    for (int i = 0; i < WAYS - 1; i++) insertOp(adr(3, 20 + i), 32'h3000 + i, 1, i % 4, "R3");
    insertOp(adr(3, 100), 32'h3100, 0, 2, "R8");
    check(!mV[3][0] || mTag[3][0] != 10, "R8", "model displaced overwritten line", 0, 0);

    // R4: a retained hit changes the replacement order
    for (int i = 0; i < WAYS; i++) insertOp(adr(1, 40 + i), 32'h1000 + i, 1, 3, "R4");
    lookupOp(2, adr(1, 40), 1, "R4");
    insertOp(adr(1, 120), 32'h1120, 1, 0, "R4");
    lookupOp(0, adr(1, 40), 1, "R4");
    lookupOp(0, adr(1, 41), 1, "R4");

    // R11: an invalidated way is reused without eviction
    lookupOp(3, adr(1, 45), 0, "R11");
    insertOp(adr(1, 121), 32'h1121, 1, 1, "R11");
    insertOp(adr(1, 122), 32'h1122, 1, 1, "R11");

    // R10: all requesters at once
    begin
      bit ev; int evA; logic [DATA_W-1:0] evD;
      bit hit[4], dty[4]; logic [DATA_W-1:0] dd[4];
      mInsert(adr(0, 7), 32'h7777_0007, 0, 3, ev, evA, evD);
      for (int c = 0; c < 4; c++) mLookup(c, adr(0, 7), c[0], hit[c], dd[c], dty[c]);
      @(negedge clk);
      insValid = 1; insAddr = ADDR_W'(adr(0, 7)); insData = 32'h7777_0007; insDirty = 0; insCore = 3;
      reqValid = 4'hF; reqIsCode = 4'b1010;
      for (int c = 0; c < 4; c++) reqAddr[c*ADDR_W +: ADDR_W] = ADDR_W'(adr(0, 7));
      #1;
      check(insReady && reqReady == 4'h0, "R10", "insert wins", reqReady, 0);
      @(negedge clk);
      insValid = 0;
      #1;
      check(!rspValid, "R10", "no response for insert", rspValid, 0);
      for (int c = 0; c < 4; c++) begin
        check(reqReady == 4'(1 << c), "R10", "grant order", reqReady, 1 << c);
        @(negedge clk);
        reqValid[c] = 0;
        check(rspValid && rspCore == 2'(c), "R10", "response core", rspCore, c);
        check(rspHit == hit[c], "R10", "response hit", rspHit, hit[c]);
        #1;
      end
    end

    // Random mix over a tag pool wider than the associativity
    begin
      void'($urandom(32'd1234));
      for (int n = 0; n < 3000; n++) begin
        int s = $urandom_range(SETS - 1);
        int t = $urandom_range(47);
        int c = $urandom_range(3);
        if ($urandom_range(1) == 0)
          insertOp(adr(s, t), $urandom, 1'($urandom_range(1)), c, "R8");
        else
          lookupOp(c, adr(s, t), 1'($urandom_range(1)), "R7");
      end
    end

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule